// File: doc/BRIEF.md
# NH Chunk Compression Hash

This block is the first, compressing stage of a keyed universal hash. A message arrives as a stream of 64-bit beats. The block cuts the stream into chunks of a fixed number of words, 16 by default (1024 bits). It reduces each chunk to a single 128-bit value, so a long message shrinks by a fixed 8:1 ratio before any slower hashing stage sees it. Words are taken in pairs. Each word of a pair is first added, modulo 2^64, to the key word at the same position in the chunk. The two sums are then multiplied to a full 128-bit product, and the products of all pairs in the chunk are summed modulo 2^128.

Every chunk uses the key from word 0 and has no link to the chunks before it. A short final chunk is padded with zero words up to the next pair boundary. Each chunk result has its two top bits cleared. The chunk's unpadded length in bits, taken modulo the chunk size, is then added at bit 64, so messages that differ only in trailing zero bytes still hash apart. Key words are written beforehand through a simple write port. Results leave on a valid/ready stream. While a result waits to be taken, the block accepts no new message words.

Top module: `nh_chunk_hash`

## Requirements
- R1: For each word pair (m_a, m_b) at chunk positions 2i and 2i+1, the block adds ((m_a + k_2i) mod 2^64) * ((m_b + k_2i+1) mod 2^64) as a 128-bit product into a chunk sum kept modulo 2^128. Sums that wrap past 2^64 are truncated.
- R2: A chunk is CHUNK_WORDS beats (16 by default). A message of n > 0 bytes yields ceil(n/128) results in order. Each chunk starts from key word 0 and from a zero sum.
- R3: Message byte j of a beat occupies in_data bits [8j+7:8j], and byte 0 is the least significant byte of the word. On a beat with in_last set, only bytes j < in_bytes (0 to 8) count, and the remaining bytes are treated as zero whatever their value.
- R4: A final chunk with an odd number of words is padded with one zero word, which still has its key word added before the multiply.
- R5: Bits 127 and 126 of the chunk sum are cleared before the length is added.
- R6: The chunk's unpadded bit length modulo CHUNK_WORDS*64 is added at bit 64. A full chunk adds zero.
- R7: A message of zero bytes is one beat with in_last=1 and in_bytes=0, and it yields exactly one result equal to 0. A zero in_bytes is allowed only in that case.
- R8: out_valid rises in the cycle after the clock edge that accepts a chunk's final beat.
- R9: While out_valid=1 and out_ready=0, out_data and out_valid hold and in_ready is 0.
- R10: A key write (key_we=1) stores key_wdata at word key_addr, and chunks accepted afterwards use the new key.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_we | input | 1 | Key word write strobe |
| key_addr | input | $clog2(CHUNK_WORDS) | Key word index |
| key_wdata | input | 64 | Key word value |
| in_valid | input | 1 | Message beat valid |
| in_ready | output | 1 | Message beat accepted when high with in_valid |
| in_data | input | 64 | Message bytes, byte 0 in the low bits |
| in_last | input | 1 | Final beat of the message |
| in_bytes | input | 4 | Valid bytes in the final beat, 0 to 8 |
| out_valid | output | 1 | Chunk result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 128 | Chunk result |

## Verification
Random keys and random message bytes are compared against a bench model of the pair arithmetic. Random keys drive the chunk sum across the whole 128-bit range, which shows whether the top bits are cleared before or after the length is added. The message lengths are chosen to separate the cases. Lengths of 0, 8, 13 and 24 bytes cover the empty chunk, single-word padding, a partial final beat and an odd word count. Lengths of 128 and 129 bytes compare an exact chunk against a one-byte spill-over chunk, so a length term or key index that fails to restart shows up. A message of all-ones bytes under all-ones keys forces the modulo-2^64 key sums to wrap. Garbage in the unused bytes shows whether masking is applied. Random and long stalls on out_ready check that results hold and intake stops, and the rise of out_valid is timed against the acceptance of each chunk's final beat.

// File: rtl/nh_pkg.sv
package nh_pkg;
  localparam int WORD_W  = 64;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = WORD_W / BYTE_W;
  localparam int DWORD_W = 2 * WORD_W;
  localparam int CNT_W   = 4;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [DWORD_W-1:0] dword_t;
  typedef logic [CNT_W-1:0]   bcnt_t;
endpackage

// File: rtl/nh_rst_sync.sv
module nh_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/nh_key_file.sv
module nh_key_file
  import nh_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output word_t         rdata_a,
  output word_t         rdata_b
);
  word_t key_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_key
    logic  en;
    word_t key_d;
    assign en    = we && (waddr == AW'(g));
    assign key_d = en ? wdata : key_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[g] <= '0;
      else        key_q[g] <= key_d;
    end
  end

  assign rdata_a = key_q[raddr_a];
  assign rdata_b = key_q[raddr_b];
endmodule

// File: rtl/nh_word_unpack.sv
module nh_word_unpack
  import nh_pkg::*;
(
  input  word_t in_data,
  input  logic  in_last,
  input  bcnt_t in_bytes,
  output word_t word
);
  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    logic keep;
    assign keep = !in_last || (CNT_W'(j) < in_bytes);
    assign word[BYTE_W*j +: BYTE_W] = keep ? in_data[BYTE_W*j +: BYTE_W] : '0;
  end
endmodule

// File: rtl/nh_pair_mac.sv
module nh_pair_mac
  import nh_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   beat_fire,
  input  logic   odd_pos,
  input  logic   pad_pair,
  input  logic   chunk_end,
  input  word_t  sum_cur,
  input  word_t  key_next,
  output dword_t acc_sum
);
  word_t  half_q, half_d;
  dword_t acc_q, acc_d;
  word_t  op_a, op_b;
  dword_t prod;
  logic   pair_done;

  always_comb begin
    pair_done = beat_fire && (odd_pos || pad_pair);
    op_a      = odd_pos ? half_q  : sum_cur;
    op_b      = odd_pos ? sum_cur : key_next;
    prod      = DWORD_W'(op_a) * DWORD_W'(op_b);
    acc_sum   = pair_done ? (acc_q + prod) : acc_q;
    half_d    = (beat_fire && !odd_pos) ? sum_cur : half_q;
    if (!beat_fire)     acc_d = acc_q;
    else if (chunk_end) acc_d = '0;
    else                acc_d = acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      acc_q  <= '0;
    end else begin
      half_q <= half_d;
      acc_q  <= acc_d;
    end
  end

  // R2: chunk-end beat must leave a cleared accumulator for the next chunk
  a_r2_acc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && chunk_end) |=> (acc_sum == '0 || (beat_fire && (odd_pos || pad_pair))));
endmodule

// File: rtl/nh_chunk_ctrl.sv
module nh_chunk_ctrl
  import nh_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS),
  localparam int CBITS = WORDS * WORD_W,
  localparam int LW   = $clog2(CBITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  bcnt_t         in_bytes,
  input  logic          out_ready,
  input  dword_t        acc_sum,
  output logic          in_ready,
  output logic          beat_fire,
  output logic [AW-1:0] idx,
  output logic [AW-1:0] idx_next_key,
  output logic          odd_pos,
  output logic          pad_pair,
  output logic          chunk_end,
  output logic          out_valid,
  output dword_t        out_data
);
  logic [AW-1:0] idx_q, idx_d;
  logic          ov_q, ov_d;
  dword_t        od_q, od_d;
  bcnt_t         beat_bytes;
  logic [LW-1:0] total_bits, len_mod;
  dword_t        cleared, result;

  always_comb begin
    in_ready     = !ov_q || out_ready;
    beat_fire    = in_valid && in_ready;
    odd_pos      = idx_q[0];
    pad_pair     = in_last && !idx_q[0] && (in_bytes != '0);
    chunk_end    = beat_fire && (in_last || idx_q == AW'(WORDS - 1));
    idx_next_key = (idx_q == AW'(WORDS - 1)) ? '0 : idx_q + AW'(1);

    beat_bytes = in_last ? in_bytes : CNT_W'(NBYTES);
    total_bits = (LW'(idx_q) << 6) + (LW'(beat_bytes) << 3);
    len_mod    = (total_bits == LW'(CBITS)) ? '0 : total_bits;
    cleared    = acc_sum & {2'b00, {(DWORD_W-2){1'b1}}};
    result     = cleared + {{(DWORD_W-WORD_W-LW){1'b0}}, len_mod, {WORD_W{1'b0}}};

    if (!beat_fire)     idx_d = idx_q;
    else if (chunk_end) idx_d = '0;
    else                idx_d = idx_q + AW'(1);

    if (chunk_end)      ov_d = 1'b1;
    else if (out_ready) ov_d = 1'b0;
    else                ov_d = ov_q;
    od_d = chunk_end ? result : od_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
    end else begin
      idx_q <= idx_d;
      ov_q  <= ov_d;
      od_q  <= od_d;
    end
  end

  assign idx       = idx_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  // R9: a result not taken stays put
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> (ov_q && $stable(od_q)));
  // R9: no message word is consumed while a result waits
  a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> $stable(idx_q));
  // R8: a new result appears only right after an accepted beat
  a_r8_valid_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_q) |-> $past(in_valid && in_ready));
  // R2: the word index restarts with each emitted chunk
  a_r2_idx_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_q) |-> (idx_q == '0));
  // R2: index stays inside the chunk
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= AW'(WORDS - 1));
endmodule

// File: rtl/nh_chunk_hash.sv
module nh_chunk_hash
  import nh_pkg::*;
#(
  parameter int CHUNK_WORDS = 16,
  localparam int AW = $clog2(CHUNK_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           key_we,
  input  logic [AW-1:0]  key_addr,
  input  logic [63:0]    key_wdata,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [63:0]    in_data,
  input  logic           in_last,
  input  logic [3:0]     in_bytes,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [127:0]   out_data
);
  logic          rst_n_s;
  logic          beat_fire, odd_pos, pad_pair, chunk_end;
  logic [AW-1:0] idx, idx_next_key;
  word_t         word, key_cur, key_next, sum_cur;
  dword_t        acc_sum;

  nh_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  nh_key_file #(.WORDS(CHUNK_WORDS)) u_keys (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (key_we),
    .waddr   (key_addr),
    .wdata   (key_wdata),
    .raddr_a (idx),
    .raddr_b (idx_next_key),
    .rdata_a (key_cur),
    .rdata_b (key_next)
  );

  nh_word_unpack u_unpack (
    .in_data  (in_data),
    .in_last  (in_last),
    .in_bytes (in_bytes),
    .word     (word)
  );

  assign sum_cur = word + key_cur;

  nh_pair_mac u_mac (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .beat_fire (beat_fire),
    .odd_pos   (odd_pos),
    .pad_pair  (pad_pair),
    .chunk_end (chunk_end),
    .sum_cur   (sum_cur),
    .key_next  (key_next),
    .acc_sum   (acc_sum)
  );

  nh_chunk_ctrl #(.WORDS(CHUNK_WORDS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .in_valid     (in_valid),
    .in_last      (in_last),
    .in_bytes     (in_bytes),
    .out_ready    (out_ready),
    .acc_sum      (acc_sum),
    .in_ready     (in_ready),
    .beat_fire    (beat_fire),
    .idx          (idx),
    .idx_next_key (idx_next_key),
    .odd_pos      (odd_pos),
    .pad_pair     (pad_pair),
    .chunk_end    (chunk_end),
    .out_valid    (out_valid),
    .out_data     (out_data)
  );

  // R7: a zero-byte final beat may only be a whole message
  a_r7_empty_only_first: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && in_last && in_bytes == 4'd0) |-> (idx == '0));
endmodule

// File: tb/nh_chunk_hash_test.sv
module nh_chunk_hash_test;
  localparam int CW = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, key_we, in_valid, in_ready, in_last, out_valid, out_ready;
  logic [AW-1:0] key_addr;
  logic [63:0]  key_wdata, in_data;
  logic [3:0]   in_bytes;
  logic [127:0] out_data;

  nh_chunk_hash #(.CHUNK_WORDS(CW)) uut (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_addr(key_addr),
    .key_wdata(key_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [63:0] keys [CW];
  logic [7:0]  msg  [512];

  logic [63:0]  bd [$];
  bit           bl [$];
  logic [3:0]   bn [$];
  bit           be [$];
  logic [127:0] eq [$];
  string        et [$];
  int           acq [$];

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_word(int base, int clen, int j);
    logic [63:0] w = '0;
    for (int b = 0; b < 8; b++)
      if (8*j + b < clen) w[8*b +: 8] = msg[base + 8*j + b];
    return w;
  endfunction

  function automatic logic [127:0] ref_chunk(int base, int clen);
    logic [127:0] acc = '0;
    logic [63:0]  s1, s2;
    int npair = (clen + 15) / 16;
    for (int p = 0; p < npair; p++) begin
      s1  = ref_word(base, clen, 2*p)     + keys[2*p];
      s2  = ref_word(base, clen, 2*p + 1) + keys[2*p + 1];
      acc = acc + 128'(s1) * 128'(s2);
    end
    acc[127:126] = 2'b00;
    return acc + ({64'd0, 64'((clen * 8) % (CW * 64))} << 64);
  endfunction

  task automatic load_keys(bit ones);
    for (int i = 0; i < CW; i++) begin
      keys[i] = ones ? '1 : {$urandom(), $urandom()};
      @(negedge clk);
      key_we = 1'b1; key_addr = AW'(i); key_wdata = keys[i];
    end
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic add_msg(int len, int fill, string tag);
    int nbeats = (len == 0) ? 1 : (len + 7) / 8;
    int nchunk = (len == 0) ? 1 : (len + 8*CW - 1) / (8*CW);
    for (int i = 0; i < len; i++) msg[i] = (fill == 1) ? 8'hFF : 8'($urandom());
    for (int c = 0; c < nchunk; c++) begin
      int clen = len - c*8*CW;
      if (clen > 8*CW) clen = 8*CW;
      eq.push_back(ref_chunk(c*8*CW, clen));
      et.push_back(tag);
    end
    for (int b = 0; b < nbeats; b++) begin
      logic [63:0] d;
      bit last = (b == nbeats - 1);
      for (int k = 0; k < 8; k++)
        d[8*k +: 8] = (8*b + k < len) ? msg[8*b + k] : 8'($urandom() | 1);
      bd.push_back(d);
      bl.push_back(last);
      bn.push_back(last ? 4'(len - 8*(nbeats - 1)) : 4'd8);
      be.push_back(last || (b % CW == CW - 1));
    end
  endtask

  task automatic run(int bp);
    bit prev_stall = 0;
    bit prev_valid = 0;
    logic [127:0] prev_data = '0;
    int n = 0;
    while (bd.size() > 0 || eq.size() > 0) begin
      @(negedge clk);
      out_ready = (bp == 0) ? 1'b1 : (bp == 1) ? 1'($urandom() % 2) : ($urandom() % 6 == 0);
      if (bd.size() > 0) begin
        in_valid = 1'b1; in_data = bd[0]; in_last = bl[0]; in_bytes = bn[0];
      end else begin
        in_valid = 1'b0; in_data = {$urandom(), $urandom()}; in_last = 1'b0; in_bytes = 4'd0;
      end
      #1;
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R9 hold", out_data, prev_data);
      if (out_valid && !out_ready)
        chk(!in_ready, "R9 intake stall", 128'(in_ready), 128'(0));
      if (out_valid && !prev_valid && acq.size() > 0)
        chk(cyc == acq[0] + 1, "R8 valid timing", 128'(cyc), 128'(acq[0] + 1));
      if (out_valid && out_ready) begin
        if (eq.size() > 0) begin
          chk(out_data == eq[0], et[0], out_data, eq[0]);
          void'(eq.pop_front()); void'(et.pop_front());
        end else chk(1'b0, "R2 extra result", out_data, '0);
        if (acq.size() > 0) void'(acq.pop_front());
      end
      if (in_valid && in_ready) begin
        if (be[0]) acq.push_back(cyc);
        void'(bd.pop_front()); void'(bl.pop_front());
        void'(bn.pop_front()); void'(be.pop_front());
      end
      prev_stall = out_valid && !out_ready;
      prev_valid = out_valid;
      prev_data  = out_data;
      n++;
      if (n > 20000) begin
        chk(1'b0, "R2 stream hung", 128'(eq.size()), 0);
        bd.delete(); bl.delete(); bn.delete(); be.delete();
        eq.delete(); et.delete(); acq.delete();
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    acq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; key_we = 1'b0; key_addr = '0; key_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_bytes = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R11 reset out_valid", 128'(out_valid), 0);
    chk(in_ready, "R11 reset in_ready", 128'(in_ready), 1);

    load_keys(1'b1);
    add_msg(16, 1, "R1 all-ones wrap");
    add_msg(8, 1, "R4 single word pad wrap");
    run(0);

    load_keys(1'b0);
    add_msg(0, 0, "R7 empty message");
    run(0);
    add_msg(16, 0, "R1 one pair");
    add_msg(13, 0, "R3 partial beat mask");
    add_msg(24, 0, "R4 odd word count pad");
    add_msg(0, 0, "R7 empty between");
    run(0);
    add_msg(128, 0, "R6 exact chunk");
    add_msg(129, 0, "R2 R6 one-byte spill");
    add_msg(300, 0, "R2 R5 three chunks");
    run(1);

    load_keys(1'b0);
    add_msg(77, 0, "R10 reloaded key");
    run(0);
    for (int i = 0; i < 12; i++) begin
      add_msg(1 + $urandom() % 400, 0, "R5 R6 random length");
      run(i % 3);
    end
    add_msg(256, 0, "R9 heavy back-pressure");
    add_msg(5, 0, "R3 R9 short tail");
    run(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule